// File: doc/BRIEF.md
# Ping-Pong DMA Buffer Status Controller

This block keeps track of two memory buffers that take turns feeding an output serializer. Software fills one buffer while the other is being read. When a buffer is ready, software writes its base address and then an acknowledge bit. The block captures that address. When the buffer's turn comes, the block offers a single fetch request to the external fetch engine. When the engine reports that the buffer is drained, the block marks it empty again and moves on to the other buffer.

Four status flags record events that software must handle:
- buffer 1 empty,
- buffer 2 empty,
- underrun (the block moved to a buffer that was never refilled),
- bus error.

Each flag has its own enable. The enabled flags are ORed onto one interrupt line. Flags are cleared by writing a one to the matching acknowledge bit.

The fetch request is a valid/ready stream. Once `fetch_valid` is high, it stays high with `fetch_addr` unchanged until `fetch_ready` is seen high on a clock edge. Exactly one such handshake occurs per acknowledged buffer. The engine may hold `fetch_ready` low for as long as it needs.

Register map (word addresses):

| Address | Name | Contents |
|---|---|---|
| 0 | control | enables in bits 3:0, acknowledge bits in 7:4 |
| 1 | status | read only |
| 2 | base 1 | base address of buffer 1 |
| 3 | base 2 | base address of buffer 2 |

Top module: `pingpong_dma_ctrl`

## Requirements
- R1: After reset all four enables and the underrun and bus-error flags are 0, both buffer-empty flags are 1, buffer 1 is the active buffer, `irq` is 0, `fetch_valid` is 0, and both base registers read 0. The status register therefore reads 0x3.
- R2: Control register (address 0) layout:
  - Bits 3:0 are read/write enables: bit0 buffer 1 empty, bit1 buffer 2 empty, bit2 underrun, bit3 bus error.
  - Bits 7:4 are write-only acknowledge bits in the same order (bit4 buffer 1 … bit7 bus error) and read as 0.
  - All other bits ignore writes and read 0.
- R3: Base registers (address 2 for buffer 1, address 3 for buffer 2) store bits 31:6 of the written word. Bits 5:0 read as 0.
- R4: Writing 1 to an acknowledge bit clears the matching flag on the next edge. Writing 0 leaves the flag unchanged.
- R5: Acknowledging an empty buffer marks it filled and captures its base register's current value. The fetch address for that buffer is the captured value, so later writes to the base register do not change a pending or future request for that fill. Acknowledging a buffer that is already filled has no effect on its address.
- R6: `fetch_valid` is high while the active buffer is filled and no request has yet been accepted for it. Once high, it holds with a stable `fetch_addr` until `fetch_ready` is high on an edge. It then drops, so there is exactly one handshake per fill.
- R7: A `buf_done` pulse after the handshake sets the active buffer's empty flag and makes the other buffer active. A `buf_done` pulse before the handshake is ignored.
- R8: If the newly active buffer is empty when the switch happens, the underrun flag sets. An acknowledge of that buffer in the same cycle as `buf_done` prevents the underrun.
- R9: A `bus_err` pulse sets the bus-error flag.
- R10: `irq` is high exactly when some flag is 1 and its enable is 1. It follows register writes and flag changes one edge later.
- R11: When a flag's set event and its acknowledge fall on the same edge, the flag ends up set.
- R12: Buffers are served in strict alternation starting with buffer 1. Acknowledging buffer 2 while buffer 1 is active and empty produces no request.
- R13: Status register (address 1), read only: bit0 buffer 1 empty, bit1 buffer 2 empty, bit2 underrun, bit3 bus error, bit4 active buffer (0 = buffer 1, 1 = buffer 2). Other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read word address |
| rd_data | output | 32 | Register read data (combinational) |
| fetch_valid | output | 1 | Fetch request valid |
| fetch_ready | input | 1 | Fetch engine accepts the request |
| fetch_addr | output | 32 | Base address of the buffer to fetch, 64-byte aligned |
| buf_done | input | 1 | Active buffer fully drained (pulse) |
| bus_err | input | 1 | Bus error seen by the fetch engine (pulse) |
| irq | output | 1 | Combined interrupt |

## Verification
The ports reveal a wrong active-buffer pointer or a lost request-issued bit within one edge:
- a request offered for the wrong address;
- a request repeated after its handshake;
- a request missing after an acknowledge.

A corrupted empty flag changes the status read and the underrun decision at the very next `buf_done`. An enabled flag shows on `irq` one edge after the event. The directed scenarios therefore read status and observe the stream pins right after each write, handshake or drain pulse. The same-edge races between set events and acknowledges receive their own checks.

// File: rtl/pp_pkg.sv
package pp_pkg;
  localparam int DATA_W   = 32;
  localparam int ALIGN_W  = 6;
  localparam int RA_W     = 2;
  localparam int FLAG_N   = 4;
  localparam int F_BUF1   = 0;
  localparam int F_BUF2   = 1;
  localparam int F_UNDR   = 2;
  localparam int F_BERR   = 3;
  localparam int ACK_LSB  = 4;
  localparam int ACT_BIT  = 4;
  localparam logic [RA_W-1:0] REG_CTRL  = 2'd0;
  localparam logic [RA_W-1:0] REG_STAT  = 2'd1;
  localparam logic [RA_W-1:0] REG_BASE1 = 2'd2;
  localparam logic [RA_W-1:0] REG_BASE2 = 2'd3;
  localparam logic [FLAG_N-1:0] FLAG_RST = 4'b0011;
endpackage

// File: rtl/pp_regs.sv
module pp_regs
  import pp_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ALIGN_W,
  localparam int BW = DW - AW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [RA_W-1:0]      wr_addr,
  input  logic [DW-1:0]        wr_data,
  input  logic [RA_W-1:0]      rd_addr,
  output logic [DW-1:0]        rd_data,
  input  logic [FLAG_N-1:0]    flags,
  input  logic                 active,
  output logic [FLAG_N-1:0]    en,
  output logic [FLAG_N-1:0]    ack,
  output logic [1:0][BW-1:0]   base
);
  logic [FLAG_N-1:0] en_q;
  logic [BW-1:0]     base_q [2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else if (wr_en && wr_addr == REG_CTRL) en_q <= wr_data[FLAG_N-1:0];
  end

  // acknowledge bits are a one-cycle pulse, never stored
  assign ack = (wr_en && wr_addr == REG_CTRL) ? wr_data[ACK_LSB +: FLAG_N] : '0;
  assign en  = en_q;

  for (genvar b = 0; b < 2; b++) begin : g_base
    localparam logic [RA_W-1:0] MY_ADDR = (b == 0) ? REG_BASE1 : REG_BASE2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) base_q[b] <= '0;
      else if (wr_en && wr_addr == MY_ADDR) base_q[b] <= wr_data[DW-1:AW];
    end
    assign base[b] = base_q[b];
  end

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      REG_CTRL:  rd_data[FLAG_N-1:0] = en_q;
      REG_STAT:  begin
        rd_data[FLAG_N-1:0] = flags;
        rd_data[ACT_BIT]    = active;
      end
      REG_BASE1: rd_data = {base_q[0], {AW{1'b0}}};
      REG_BASE2: rd_data = {base_q[1], {AW{1'b0}}};
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/pp_flags.sv
module pp_flags
  import pp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_N-1:0] set,
  input  logic [FLAG_N-1:0] clr,
  output logic [FLAG_N-1:0] flags
);
  logic [FLAG_N-1:0] flag_q;

  for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag_q[i] <= FLAG_RST[i];
      else if (set[i]) flag_q[i] <= 1'b1;
      else if (clr[i]) flag_q[i] <= 1'b0;
    end

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !set[i]) |=> !flags[i]); // R4
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> flags[i]); // R11
  end

  assign flags = flag_q;
endmodule

// File: rtl/pp_seq.sv
module pp_seq
  import pp_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ALIGN_W,
  localparam int BW = DW - AW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         ack_buf,
  input  logic [1:0][BW-1:0] base,
  input  logic [1:0]         empty,
  input  logic               fetch_ready,
  input  logic               buf_done,
  output logic               fetch_valid,
  output logic [DW-1:0]      fetch_addr,
  output logic [1:0]         drain_set,
  output logic               underrun_set,
  output logic               active
);
  logic          act_q;
  logic          issued_q;
  logic [BW-1:0] cap_q [2];
  logic          other;
  logic          drain;

  assign other = ~act_q;
  assign drain = buf_done & issued_q;

  // address captured only when an empty buffer is handed back
  for (genvar b = 0; b < 2; b++) begin : g_cap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cap_q[b] <= '0;
      else if (ack_buf[b] && empty[b]) cap_q[b] <= base[b];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q    <= 1'b0;
      issued_q <= 1'b0;
    end else if (drain) begin
      act_q    <= other;
      issued_q <= 1'b0;
    end else if (fetch_valid && fetch_ready) begin
      issued_q <= 1'b1;
    end
  end

  assign fetch_valid  = ~empty[act_q] & ~issued_q;
  assign fetch_addr   = {cap_q[act_q], {AW{1'b0}}};
  assign drain_set    = drain ? (act_q ? 2'b10 : 2'b01) : 2'b00;
  assign underrun_set = drain & empty[other] & ~ack_buf[other];
  assign active       = act_q;

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !fetch_ready) |=> (fetch_valid && $stable(fetch_addr))); // R6
  AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && fetch_ready) |=> !fetch_valid); // R6
endmodule

// File: rtl/pingpong_dma_ctrl.sv
module pingpong_dma_ctrl
  import pp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [RA_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [RA_W-1:0]   rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              fetch_valid,
  input  logic              fetch_ready,
  output logic [DATA_W-1:0] fetch_addr,
  input  logic              buf_done,
  input  logic              bus_err,
  output logic              irq
);
  localparam int BW = DATA_W - ALIGN_W;

  logic [FLAG_N-1:0] flags, en, ack, set;
  logic [1:0][BW-1:0] base;
  logic [1:0] drain_set;
  logic underrun_set, active;

  pp_regs #(.DW(DATA_W), .AW(ALIGN_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .flags(flags), .active(active), .en(en), .ack(ack), .base(base)
  );

  pp_seq #(.DW(DATA_W), .AW(ALIGN_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .ack_buf(ack[F_BUF2:F_BUF1]), .base(base),
    .empty(flags[F_BUF2:F_BUF1]), .fetch_ready(fetch_ready),
    .buf_done(buf_done), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .drain_set(drain_set), .underrun_set(underrun_set), .active(active)
  );

  always_comb begin
    set         = '0;
    set[F_BUF1] = drain_set[0];
    set[F_BUF2] = drain_set[1];
    set[F_UNDR] = underrun_set;
    set[F_BERR] = bus_err;
  end

  pp_flags u_flags (
    .clk(clk), .rst_n(rst_n), .set(set), .clr(ack), .flags(flags)
  );

  assign irq = |(flags & en);

  AST_DRAIN_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (|drain_set) |=> (flags[$past(active)] && active != $past(active))); // R7
  AST_UNDERRUN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_set |=> flags[F_UNDR]); // R8
  AST_BUSERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |=> flags[F_BERR]); // R9
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !irq); // R10
endmodule

// File: tb/tb_pingpong_dma_ctrl.sv
module tb_pingpong_dma_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        fetch_valid;
  logic        fetch_ready = 1'b0;
  logic [31:0] fetch_addr;
  logic        buf_done = 1'b0;
  logic        bus_err = 1'b0;
  logic        irq;

  int n_run = 0;
  int n_fail = 0;

  pingpong_dma_ctrl dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
    .fetch_addr(fetch_addr), .buf_done(buf_done), .bus_err(bus_err),
    .irq(irq)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 0; fetch_ready = 0; buf_done = 0; bus_err = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic handshake();
    @(negedge clk); fetch_ready = 1'b1;
    @(negedge clk); fetch_ready = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk); buf_done = 1'b1;
    @(negedge clk); buf_done = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    rd(2'd1, d); chk("R1 status after reset", d, 32'h3);
    rd(2'd0, d); chk("R1 control after reset", d, 32'h0);
    rd(2'd2, d); chk("R1 base1 after reset", d, 32'h0);
    rd(2'd3, d); chk("R1 base2 after reset", d, 32'h0);
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
    chk("R1 fetch_valid after reset", {31'b0, fetch_valid}, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    do_reset();
    wr(2'd0, 32'hFFFF_FF0F);
    rd(2'd0, d); chk("R2 enables and reserved bits", d, 32'h0000_000F);
    rd(2'd1, d); chk("R13 status unchanged by reserved writes", d, 32'h3);
    chk("R10 irq with buffer-empty flags enabled", {31'b0, irq}, 32'h1);
    wr(2'd0, 32'h0000_0004);
    chk("R10 irq when only underrun enabled", {31'b0, irq}, 32'h0);
    wr(2'd0, 32'h0000_0002);
    chk("R10 irq when buffer 2 empty enabled", {31'b0, irq}, 32'h1);
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, d); chk("R3 base1 low bits zero", d, 32'hFFFF_FFC0);
    wr(2'd3, 32'h1234_5678);
    rd(2'd3, d); chk("R3 base2 low bits zero", d, 32'h1234_5640);
    wr(2'd0, 32'h0000_0000);
    rd(2'd1, d); chk("R4 ack written as zero leaves flags", d, 32'h3);
    chk("R10 irq with enables cleared", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_alternate();
    logic [31:0] d;
    do_reset();
    wr(2'd3, 32'h0000_3000);
    wr(2'd0, 32'h0000_0020);
    chk("R12 ack of buffer 2 first gives no request", {31'b0, fetch_valid}, 32'h0);
    rd(2'd1, d); chk("R4 ack buffer 2 clears its flag", d, 32'h1);
    wr(2'd2, 32'h0000_1000);
    wr(2'd0, 32'h0000_0010);
    chk("R5 request after ack of buffer 1", {31'b0, fetch_valid}, 32'h1);
    chk("R5 captured address buffer 1", fetch_addr, 32'h0000_1000);
    wr(2'd2, 32'h0000_2000);
    chk("R5 later base write leaves address", fetch_addr, 32'h0000_1000);
    wr(2'd0, 32'h0000_0010);
    chk("R5 repeat ack of filled buffer leaves address", fetch_addr, 32'h0000_1000);
    drain();
    rd(2'd1, d); chk("R7 drain before handshake ignored", d, 32'h0);
    repeat (3) @(negedge clk);
    chk("R6 valid held without ready", {31'b0, fetch_valid}, 32'h1);
    chk("R6 address stable without ready", fetch_addr, 32'h0000_1000);
    handshake();
    chk("R6 valid drops after handshake", {31'b0, fetch_valid}, 32'h0);
    drain();
    rd(2'd1, d); chk("R7 drain empties buffer 1 and switches", d, 32'h11);
    chk("R12 buffer 2 requested next", {31'b0, fetch_valid}, 32'h1);
    chk("R5 captured address buffer 2", fetch_addr, 32'h0000_3000);
    handshake();
    drain();
    rd(2'd1, d); chk("R8 switch to empty buffer 1 sets underrun", d, 32'h07);
    chk("R8 no request for empty buffer", {31'b0, fetch_valid}, 32'h0);
    wr(2'd0, 32'h0000_0040);
    rd(2'd1, d); chk("R4 ack underrun clears it", d, 32'h03);
  endtask

  task automatic t_race();
    logic [31:0] d;
    do_reset();
    wr(2'd2, 32'h0000_0400);
    wr(2'd0, 32'h0000_0010);
    handshake();
    @(negedge clk);
    buf_done = 1'b1; wr_en = 1'b1; wr_addr = 2'd0; wr_data = 32'h0000_0020;
    @(negedge clk);
    buf_done = 1'b0; wr_en = 1'b0; wr_data = '0;
    rd(2'd1, d); chk("R8 same-edge ack of buffer 2 averts underrun", d, 32'h11);
    chk("R8 buffer 2 requested after race", {31'b0, fetch_valid}, 32'h1);
    wr(2'd0, 32'h0000_0008);
    @(negedge clk); bus_err = 1'b1;
    @(negedge clk); bus_err = 1'b0;
    rd(2'd1, d); chk("R9 bus error sets flag", d, 32'h19);
    chk("R10 irq on enabled bus error", {31'b0, irq}, 32'h1);
    @(negedge clk);
    bus_err = 1'b1; wr_en = 1'b1; wr_addr = 2'd0; wr_data = 32'h0000_0088;
    @(negedge clk);
    bus_err = 1'b0; wr_en = 1'b0; wr_data = '0;
    rd(2'd1, d); chk("R11 set wins over same-edge ack", d, 32'h19);
    wr(2'd0, 32'h0000_0088);
    rd(2'd1, d); chk("R4 ack bus error clears it", d, 32'h11);
    chk("R10 irq drops after clear", {31'b0, irq}, 32'h0);
  endtask

  initial begin
    t_reset();
    t_regs();
    t_alternate();
    t_race();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule